// File: doc/BRIEF.md
# Per-Stream Ingress Timing Gate

This block performs time-window admission control for identified traffic streams at a switch ingress. A small table holds flow keys. A key is either VLAN-aware, matching destination MAC, VLAN ID and priority code point, or VLAN-unaware, matching destination MAC alone. Each flow carries a cyclic gate schedule: an open interval followed by a closed interval, repeating from a base time given in nanoseconds. Each flow also holds a routing destination mask and a maximum frame length.

For every frame descriptor presented on the input stream, the block looks the key up, evaluates the matched flow's gate at the frame's arrival timestamp, and checks the destination mask and the length. It then returns a pass/drop verdict with the matched index on the output stream. Frames that match no flow bypass the gate. Every dropped frame on a matched flow increments that flow's saturating frame counter. A single counter covers all drop causes, and no byte counter exists. Software can read and clear each counter by index.

The input stream is accepted (`frm_valid && frm_ready`) only when the single-entry result register is empty or is being drained in the same cycle. A stalled result (`res_valid && !res_ready`) holds all result fields stable and deasserts `frm_ready`. The verdict appears on the clock edge that accepts the descriptor.

Top module: `psg_ingress_gate`

## Requirements
- R1: A VLAN-aware enabled entry matches only a tagged frame whose destination MAC, VLAN ID and PCP all equal the entry's key.
- R2: A VLAN-unaware enabled entry matches on destination MAC alone, for tagged and untagged frames alike.
- R3: When several enabled entries match, the lowest index wins and is reported on `res_idx`.
- R4: A frame matching no enabled entry is passed with `res_hit` = 0 and `res_idx` = 0, and touches no counter.
- R5: A matched frame's gate is open only when `frm_time` >= base and ((`frm_time` - base) mod (open + close)) < open. Arrival before the base time, or a zero-length period, counts as closed. A closed gate drops the frame. For example, with base 1000, open 60000 and close 40000, arrival at 61000 is dropped and arrival at 101000 passes.
- R6: A matched frame whose flow has an all-zero destination mask is dropped, even when the gate is open.
- R7: A matched frame with `frm_len` greater than the flow's maximum length is dropped; a length equal to the maximum passes.
- R8: Each dropped matched frame increments that flow's counter by one; passed frames do not.
- R9: A counter at its all-ones value (2^CNT_W - 1, default 32 bits) stays there on further drops.
- R10: A `clr_pulse` with `clr_idx` zeroes that counter. Clear takes precedence over a drop in the same cycle.
- R11: While `res_valid` is high and `res_ready` is low, the result fields stay stable and `frm_ready` is low. When `res_ready` is high, a new descriptor is accepted in the same cycle.
- R12: After reset, `res_valid` is 0, all counters read 0 and every table entry is disabled. Configuration writes or clears whose index is at or above the table depth are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_en | input | 1 | Entry enable |
| cfg_aware | input | 1 | 1: key includes VLAN ID and PCP |
| cfg_mac | input | 48 | Destination MAC key |
| cfg_vid | input | 12 | VLAN ID key |
| cfg_pcp | input | 3 | PCP key |
| cfg_dest | input | PORTS | Routing destination mask |
| cfg_mtu | input | LEN_W | Maximum admitted frame length |
| cfg_base | input | TIME_W | Schedule base time (ns) |
| cfg_open | input | TIME_W | Open interval (ns) |
| cfg_close | input | TIME_W | Closed interval (ns) |
| frm_valid | input | 1 | Frame descriptor valid |
| frm_ready | output | 1 | Descriptor accepted this cycle |
| frm_mac | input | 48 | Frame destination MAC |
| frm_tagged | input | 1 | Frame carries a VLAN tag |
| frm_vid | input | 12 | Frame VLAN ID |
| frm_pcp | input | 3 | Frame PCP |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_time | input | TIME_W | Arrival timestamp (ns) |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Verdict consumer ready |
| res_pass | output | 1 | 1 admit, 0 drop |
| res_hit | output | 1 | Frame matched a flow |
| res_idx | output | IDX_W | Matched flow index |
| clr_pulse | input | 1 | Clear one drop counter |
| clr_idx | input | IDX_W | Counter index to clear |
| cnt_rd_idx | input | IDX_W | Counter index to read |
| cnt_rd_val | output | CNT_W | Counter value at `cnt_rd_idx` |

## Verification
A corrupted key compare or priority order shows up as a wrong `res_hit` or `res_idx` in the cycle after the descriptor is accepted. An off-by-one in the gate phase shows up only at the exact edges of a window, so those edges are probed at both boundaries and across a period wrap. A counter fault, whether missed increments, wrap-around instead of saturation, or clear losing to a drop, is visible on `cnt_rd_val` right after the same edge that produces the verdict. A stall fault shows up as a changed result or an accepted descriptor while the output is held.

// File: rtl/psg_pkg.sv
`timescale 1ns/1ps
package psg_pkg;
  localparam int MAC_W = 48;
  localparam int VID_W = 12;
  localparam int PCP_W = 3;

  typedef struct packed {
    logic [MAC_W-1:0] mac;
    logic [VID_W-1:0] vid;
    logic [PCP_W-1:0] pcp;
  } flow_key_t;
endpackage

// File: rtl/psg_key_match.sv
`timescale 1ns/1ps
module psg_key_match
  import psg_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 10
) (
  input  logic             ent_en    [DEPTH],
  input  logic             ent_aware [DEPTH],
  input  flow_key_t        ent_key   [DEPTH],
  input  flow_key_t        frm_key,
  input  logic             frm_tagged,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  logic [DEPTH-1:0] match_vec;

  // One comparator per entry.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic mac_eq, tag_eq;
    assign mac_eq = (ent_key[g].mac == frm_key.mac);
    assign tag_eq = frm_tagged && (ent_key[g].vid == frm_key.vid)
                                && (ent_key[g].pcp == frm_key.pcp);
    assign match_vec[g] = ent_en[g] && mac_eq && (!ent_aware[g] || tag_eq);
  end

  // Lowest index has priority: scan downward so the last write wins.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/psg_gate_eval.sv
`timescale 1ns/1ps
module psg_gate_eval #(
  parameter int TIME_W = 32
) (
  input  logic [TIME_W-1:0] base,
  input  logic [TIME_W-1:0] open_len,
  input  logic [TIME_W-1:0] close_len,
  input  logic [TIME_W-1:0] now,
  output logic              gate_open
);
  localparam int EXT_W = TIME_W + 1;

  logic [EXT_W-1:0] period, elapsed, phase;

  always_comb begin
    period  = {1'b0, open_len} + {1'b0, close_len};
    elapsed = {1'b0, now} - {1'b0, base};
    phase   = '0;
    gate_open = 1'b0;
    if ((now >= base) && (period != '0)) begin
      phase     = elapsed % period;
      gate_open = (phase < {1'b0, open_len});
    end
  end
endmodule

// File: rtl/psg_drop_counters.sv
`timescale 1ns/1ps
module psg_drop_counters #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 10,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_val
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cnt
    logic clr_hit, inc_hit;
    assign clr_hit = clr_en && (clr_idx == IDX_W'(g));
    assign inc_hit = inc_en && (inc_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt_q[g] <= '0;
      else if (clr_hit)                      cnt_q[g] <= '0;
      else if (inc_hit && cnt_q[g] != CNT_MAX) cnt_q[g] <= cnt_q[g] + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_hit && !clr_hit && cnt_q[g] != CNT_MAX) |=> (cnt_q[g] == $past(cnt_q[g]) + 1'b1)); // R8
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g] == CNT_MAX && !clr_hit) |=> (cnt_q[g] == CNT_MAX)); // R9
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit |=> (cnt_q[g] == '0)); // R10
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx == IDX_W'(i)) rd_val = cnt_q[i];
  end
endmodule

// File: rtl/psg_ingress_gate.sv
`timescale 1ns/1ps
module psg_ingress_gate
  import psg_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 10,
  parameter int PORTS  = 4,
  parameter int LEN_W  = 14,
  parameter int TIME_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic              cfg_aware,
  input  logic [47:0]       cfg_mac,
  input  logic [11:0]       cfg_vid,
  input  logic [2:0]        cfg_pcp,
  input  logic [PORTS-1:0]  cfg_dest,
  input  logic [LEN_W-1:0]  cfg_mtu,
  input  logic [TIME_W-1:0] cfg_base,
  input  logic [TIME_W-1:0] cfg_open,
  input  logic [TIME_W-1:0] cfg_close,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [47:0]       frm_mac,
  input  logic              frm_tagged,
  input  logic [11:0]       frm_vid,
  input  logic [2:0]        frm_pcp,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [TIME_W-1:0] frm_time,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_pass,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_idx,
  input  logic              clr_pulse,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  cnt_rd_idx,
  output logic [CNT_W-1:0]  cnt_rd_val
);
  // Flow table storage.
  logic              t_en    [DEPTH];
  logic              t_aware [DEPTH];
  flow_key_t         t_key   [DEPTH];
  logic [PORTS-1:0]  t_dest  [DEPTH];
  logic [LEN_W-1:0]  t_mtu   [DEPTH];
  logic [TIME_W-1:0] t_base  [DEPTH];
  logic [TIME_W-1:0] t_open  [DEPTH];
  logic [TIME_W-1:0] t_close [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tab
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_en[g]    <= 1'b0;
        t_aware[g] <= 1'b0;
        t_key[g]   <= '0;
        t_dest[g]  <= '0;
        t_mtu[g]   <= '0;
        t_base[g]  <= '0;
        t_open[g]  <= '0;
        t_close[g] <= '0;
      end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
        t_en[g]    <= cfg_en;
        t_aware[g] <= cfg_aware;
        t_key[g]   <= '{mac: cfg_mac, vid: cfg_vid, pcp: cfg_pcp};
        t_dest[g]  <= cfg_dest;
        t_mtu[g]   <= cfg_mtu;
        t_base[g]  <= cfg_base;
        t_open[g]  <= cfg_open;
        t_close[g] <= cfg_close;
      end
    end
  end

  // Lookup.
  flow_key_t        frm_key;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;

  assign frm_key = '{mac: frm_mac, vid: frm_vid, pcp: frm_pcp};

  psg_key_match #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_match (
    .ent_en    (t_en),
    .ent_aware (t_aware),
    .ent_key   (t_key),
    .frm_key   (frm_key),
    .frm_tagged(frm_tagged),
    .hit       (lk_hit),
    .hit_idx   (lk_idx)
  );

  // Select the matched flow's parameters.
  logic [PORTS-1:0]  sel_dest;
  logic [LEN_W-1:0]  sel_mtu;
  logic [TIME_W-1:0] sel_base, sel_open, sel_close;

  always_comb begin
    sel_dest  = '0;
    sel_mtu   = '0;
    sel_base  = '0;
    sel_open  = '0;
    sel_close = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lk_idx == IDX_W'(i)) begin
        sel_dest  = t_dest[i];
        sel_mtu   = t_mtu[i];
        sel_base  = t_base[i];
        sel_open  = t_open[i];
        sel_close = t_close[i];
      end
    end
  end

  logic gate_open;

  psg_gate_eval #(.TIME_W(TIME_W)) u_gate (
    .base     (sel_base),
    .open_len (sel_open),
    .close_len(sel_close),
    .now      (frm_time),
    .gate_open(gate_open)
  );

  // Verdict.
  logic admit, accept;
  assign admit     = !lk_hit || (gate_open && (sel_dest != '0) && (frm_len <= sel_mtu));
  assign frm_ready = !res_valid || res_ready;
  assign accept    = frm_valid && frm_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_pass  <= admit;
      res_hit   <= lk_hit;
      res_idx   <= lk_hit ? lk_idx : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // Drop counters.
  psg_drop_counters #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_en (accept && lk_hit && !admit),
    .inc_idx(lk_idx),
    .clr_en (clr_pulse),
    .clr_idx(clr_idx),
    .rd_idx (cnt_rd_idx),
    .rd_val (cnt_rd_val)
  );

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pass) && $stable(res_hit)
                                   && $stable(res_idx))); // R11
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_idx < IDX_W'(DEPTH))); // R3
  AST_CLOSED_BEFORE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lk_hit && frm_time < sel_base) |=> !res_pass); // R5
  AST_NOHIT_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_idx == '0 && res_pass)); // R4
endmodule

// File: tb/psg_ingress_gate_test.sv
`timescale 1ns/1ps
module psg_ingress_gate_test;
  localparam int DEPTH = 8, IDX_W = 10, PORTS = 4, LEN_W = 14, TIME_W = 32, CNT_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_en = 0, cfg_aware = 0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [47:0] cfg_mac = '0;
  logic [11:0] cfg_vid = '0;
  logic [2:0] cfg_pcp = '0;
  logic [PORTS-1:0] cfg_dest = '0;
  logic [LEN_W-1:0] cfg_mtu = '0;
  logic [TIME_W-1:0] cfg_base = '0, cfg_open = '0, cfg_close = '0;
  logic frm_valid = 0, frm_tagged = 0, frm_ready;
  logic [47:0] frm_mac = '0;
  logic [11:0] frm_vid = '0;
  logic [2:0] frm_pcp = '0;
  logic [LEN_W-1:0] frm_len = '0;
  logic [TIME_W-1:0] frm_time = '0;
  logic res_valid, res_ready = 1, res_pass, res_hit;
  logic [IDX_W-1:0] res_idx;
  logic clr_pulse = 0;
  logic [IDX_W-1:0] clr_idx = '0, cnt_rd_idx = '0;
  logic [CNT_W-1:0] cnt_rd_val;

  int n_chk = 0, n_bad = 0;

  localparam logic [47:0] MAC_A = 48'h42be249b7620;
  localparam logic [47:0] MAC_B = 48'h0a1122334455;
  localparam logic [47:0] MAC_C = 48'h0affeeddccbb;
  localparam logic [47:0] MAC_X = 48'h0a0000000001;

  always #10 clk = ~clk;

  psg_ingress_gate #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PORTS(PORTS), .LEN_W(LEN_W),
                     .TIME_W(TIME_W), .CNT_W(CNT_W)) uut (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input bit en, input bit aware, input [47:0] mac,
                     input [11:0] vid, input [2:0] pcp, input [PORTS-1:0] dest,
                     input int mtu, input int base, input int op, input int cl);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_en = en; cfg_aware = aware; cfg_mac = mac;
    cfg_vid = vid; cfg_pcp = pcp; cfg_dest = dest; cfg_mtu = LEN_W'(mtu);
    cfg_base = TIME_W'(base); cfg_open = TIME_W'(op); cfg_close = TIME_W'(cl);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Drive one descriptor; result is visible at the following negedge.
  task automatic send(input [47:0] mac, input [11:0] vid, input [2:0] pcp, input bit tag,
                      input int len, input int t);
    @(negedge clk);
    frm_valid = 1; frm_mac = mac; frm_vid = vid; frm_pcp = pcp; frm_tagged = tag;
    frm_len = LEN_W'(len); frm_time = TIME_W'(t);
    @(posedge clk);
    @(negedge clk);
    frm_valid = 0;
  endtask

  task automatic expect_res(input string req, input bit hit, input int idx, input bit pass);
    chk(req, "res_valid", res_valid, 1);
    chk(req, "res_hit", res_hit, hit);
    chk(req, "res_idx", res_idx, idx);
    chk(req, "res_pass", res_pass, pass);
  endtask

  task automatic expect_cnt(input string req, input int idx, input int exp);
    cnt_rd_idx = IDX_W'(idx);
    #1;
    chk(req, $sformatf("counter[%0d]", idx), cnt_rd_val, exp);
  endtask

  task automatic t_reset;
    chk("R12", "res_valid after reset", res_valid, 0);
    chk("R11", "frm_ready after reset", frm_ready, 1);
    for (int i = 0; i < DEPTH; i++) expect_cnt("R12", i, 0);
    send(MAC_A, 12'd100, 3'd0, 1, 64, 5000);
    expect_res("R12", 0, 0, 1);
  endtask

  task automatic t_keys;
    cfg(2, 1, 1, MAC_A, 12'd100, 3'd0, 4'b0011, 1500, 1000, 60000, 40000);
    cfg(5, 1, 0, MAC_B, 12'd0, 3'd0, 4'b0011, 1500, 1000, 60000, 40000);
    send(MAC_A, 12'd100, 3'd0, 1, 64, 1010);  expect_res("R1", 1, 2, 1);
    send(MAC_A, 12'd101, 3'd0, 1, 64, 1010);  expect_res("R1", 0, 0, 1);
    send(MAC_A, 12'd100, 3'd1, 1, 64, 1010);  expect_res("R1", 0, 0, 1);
    send(MAC_A, 12'd100, 3'd0, 0, 64, 1010);  expect_res("R1", 0, 0, 1);
    send(MAC_B, 12'd7, 3'd5, 1, 64, 1010);    expect_res("R2", 1, 5, 1);
    send(MAC_B, 12'd0, 3'd0, 0, 64, 1010);    expect_res("R2", 1, 5, 1);
    send(MAC_X, 12'd100, 3'd0, 1, 64, 1010);  expect_res("R4", 0, 0, 1);
  endtask

  task automatic t_priority;
    cfg(1, 1, 0, MAC_A, 12'd0, 3'd0, 4'b0001, 1500, 0, 100, 0);
    send(MAC_A, 12'd100, 3'd0, 1, 64, 50);    expect_res("R3", 1, 1, 1);
    cfg(1, 0, 0, MAC_A, 12'd0, 3'd0, 4'b0001, 1500, 0, 100, 0);
    send(MAC_A, 12'd100, 3'd0, 1, 64, 1010);  expect_res("R3", 1, 2, 1);
    // write beyond depth is ignored
    cfg(8, 1, 0, MAC_X, 12'd0, 3'd0, 4'b0001, 1500, 0, 100, 0);
    send(MAC_X, 12'd0, 3'd0, 0, 64, 10);      expect_res("R12", 0, 0, 1);
  endtask

  task automatic t_gate;
    send(MAC_B, 0, 0, 0, 64, 500);     expect_res("R5", 1, 5, 0);
    send(MAC_B, 0, 0, 0, 64, 1000);    expect_res("R5", 1, 5, 1);
    send(MAC_B, 0, 0, 0, 64, 60999);   expect_res("R5", 1, 5, 1);
    send(MAC_B, 0, 0, 0, 64, 61000);   expect_res("R5", 1, 5, 0);
    send(MAC_B, 0, 0, 0, 64, 100999);  expect_res("R5", 1, 5, 0);
    send(MAC_B, 0, 0, 0, 64, 101000);  expect_res("R5", 1, 5, 1);
    send(MAC_B, 0, 0, 0, 64, 161000);  expect_res("R5", 1, 5, 0);
    expect_cnt("R8", 5, 4);
    expect_cnt("R8", 2, 0);
    expect_cnt("R4", 0, 0);
  endtask

  task automatic t_dest_mtu;
    cfg(3, 1, 0, MAC_C, 0, 0, 4'b0000, 1500, 0, 1000, 0);
    send(MAC_C, 0, 0, 0, 64, 10);      expect_res("R6", 1, 3, 0);
    expect_cnt("R6", 3, 1);
    send(MAC_B, 0, 0, 0, 1500, 1010);  expect_res("R7", 1, 5, 1);
    send(MAC_B, 0, 0, 0, 1501, 1010);  expect_res("R7", 1, 5, 0);
    expect_cnt("R8", 5, 5);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 16; i++) send(MAC_C, 0, 0, 0, 64, 10);
    expect_cnt("R9", 3, 15);
  endtask

  task automatic t_clear;
    @(negedge clk); clr_pulse = 1; clr_idx = 10'd3;
    @(posedge clk); @(negedge clk); clr_pulse = 0;
    expect_cnt("R10", 3, 0);
    send(MAC_C, 0, 0, 0, 64, 10);
    expect_cnt("R8", 3, 1);
    // clear coincides with a drop on the same flow
    @(negedge clk);
    frm_valid = 1; frm_mac = MAC_C; frm_tagged = 0; frm_len = 64; frm_time = 10;
    clr_pulse = 1; clr_idx = 10'd3;
    @(posedge clk); @(negedge clk);
    frm_valid = 0; clr_pulse = 0;
    expect_res("R10", 1, 3, 0);
    expect_cnt("R10", 3, 0);
    // clear beyond depth is ignored
    @(negedge clk); clr_pulse = 1; clr_idx = 10'd13;
    @(posedge clk); @(negedge clk); clr_pulse = 0;
    expect_cnt("R12", 5, 5);
  endtask

  task automatic t_backpressure;
    res_ready = 0;
    send(MAC_B, 0, 0, 0, 64, 1010);
    expect_res("R11", 1, 5, 1);
    @(negedge clk);
    frm_valid = 1; frm_mac = MAC_X; frm_tagged = 0; frm_time = 20;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R11", "frm_ready while stalled", frm_ready, 0);
      expect_res("R11", 1, 5, 1);
    end
    res_ready = 1;
    #1 chk("R11", "frm_ready on drain", frm_ready, 1);
    @(posedge clk); @(negedge clk);
    frm_valid = 0;
    expect_res("R11", 0, 0, 1);
    @(posedge clk); @(negedge clk);
    chk("R11", "res_valid after drain", res_valid, 0);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_keys();
    t_priority();
    t_gate();
    t_dest_mtu();
    t_saturate();
    t_clear();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule